// File: doc/BRIEF.md
# Asynchronous Page-Mode Pseudo-SRAM Controller

This block is a clocked host controller for an external asynchronous pseudo-SRAM with a 16-bit data bus. An internal client asks for work on a simple request port. Each request carries a read or write flag, a 22-bit word address, write data, two byte-lane enables and a burst length. The controller turns each request into the active-low strobe sequence the memory expects: chip enable, output enable, write enable and the two byte-lane enables. It steps through the access phases with cycle counters. Every counter limit comes from a nanosecond timing figure, rounded up at elaboration time to whole cycles of the configured clock period.

Reads may be bursts of up to 16 words. When the page-mode input is set, every word after the first that stays inside the same 16-word page needs only the short in-page access time. A burst that runs past the page end is split there and restarts as a fresh random access. The controller also counts how long chip enable has been low. It raises chip enable before that time would pass the device's limit, so the device can schedule its hidden refresh. Writes are always single words and always end with chip enable raised. After reset the controller holds chip enable high for the power-up interval before it accepts any request. The data pads are split into input, output and drive-enable signals, and the output drive is on only around write pulses.

Top module: `psram_ctrl`

## Requirements
- R1: After reset release, `mem_ce_no` stays high and `ready_o` stays low for exactly PU_CYC = ceil(T_PU_PS / CLK_PS) rising edges. `ready_o` is first high after edge PU_CYC. `mem_dq_oe_o` and `rvalid_o` are low in reset.
- R2: A read accepted at edge E0 (`req_i` and `ready_o` high, `we_i` low) drives `mem_ce_no`, `mem_oe_no` and the selected byte-lane enables low with `mem_we_no` high. The first word is sampled at edge E0 + AA_CYC, where AA_CYC = ceil(T_AA_PS / CLK_PS). It is shown on `rdata_o` with `rvalid_o` high for one cycle.
- R3: A write holds `mem_ce_no` and `mem_we_no` low for WR_CYC = max(ceil(T_WP_PS/CLK_PS), ceil(T_DW_PS/CLK_PS)) cycles, with `mem_oe_no` high. `mem_dq_o` carries the write data, driven from the first write cycle until the cycle in which `mem_we_no` rises.
- R4: `be_i[0]` selects the lower byte (data bits 7:0, pin `mem_be_no[0]`) and `be_i[1]` the upper byte (bits 15:8, `mem_be_no[1]`). A disabled lane is not written, and on reads it is returned as 8'h00 on `rdata_o`.
- R5: With `page_en_i` high, each further word of a read burst whose address stays in the same 16-word page is sampled APA_CYC = ceil(T_APA_PS/CLK_PS) edges after the previous one. Chip enable stays low, and address bits [21:4] do not change while chip enable is low.
- R6: A burst word whose predecessor has address bits [3:0] = 4'hF is fetched as a new random access. Chip enable goes high for one cycle and the word is sampled AA_CYC edges after chip enable falls again.
- R7: With `page_en_i` low, every word of a read burst is a random access separated by a one-cycle chip-enable-high gap.
- R8: Chip enable is never low for more than CEM_CYC = ceil(T_CEM_PS/CLK_PS) consecutive cycles. A page step that would pass that bound is replaced by a one-cycle gap and a new random access.
- R9: `mem_dq_oe_o` is never high while `mem_oe_no` is low, and it is low in the cycle before `mem_oe_no` falls.
- R10: `len_i` (burst length = `len_i` + 1 words) applies to reads only. A write request produces exactly one write pulse.
- R11: `req_i` is ignored whenever `ready_o` is low: during power-up and while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| page_en_i | input | 1 | Page-mode reads permitted |
| req_i | input | 1 | Request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 22 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte-lane enables, bit 0 lower, bit 1 upper |
| len_i | input | 4 | Read burst length minus one |
| ready_o | output | 1 | Idle and accepting a request this cycle |
| rvalid_o | output | 1 | Read word valid |
| rdata_o | output | 16 | Read word, disabled lanes zero |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_be_no | output | 2 | Memory byte-lane enables, active low |
| mem_addr_o | output | 22 | Memory address |
| mem_dq_i | input | 16 | Data from the memory pads |
| mem_dq_o | output | 16 | Data to the memory pads |
| mem_dq_oe_o | output | 1 | Pad output drive enable |

## Verification
Reads are tried with single words, in-page bursts, bursts that cross a page end and bursts with page mode off. The arrival cycle of each word separates the short in-page step from a full random access that follows a gap. A long in-page burst under a reduced chip-enable limit shows the bound forcing a split where the page alone would not. Partial-lane writes followed by full-lane reads show which bytes changed, and a write carrying a non-zero length shows that only one pulse is issued. Requests raised during power-up or during a busy read are shown to be dropped by reading the target word back unchanged.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [2:0] {
    ST_PWR, ST_IDLE, ST_RD, ST_PG, ST_GAP, ST_WR, ST_WEND
  } psram_st_e;

  // round a picosecond figure up to whole clock cycles, never below one
  function automatic int ps2cyc(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/psram_lanes.sv
module psram_lanes #(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0]   be_i,
  input  logic               active_i,
  input  logic [8*LANES-1:0] dq_i,
  output logic [LANES-1:0]   lane_n_o,
  output logic [8*LANES-1:0] masked_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_n_o[i]        = ~(active_i & be_i[i]);
    assign masked_o[8*i +: 8] = be_i[i] ? dq_i[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/psram_pwrup_wait.sv
module psram_pwrup_wait #(
  parameter int CYC = 15000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int W = $clog2(CYC + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= W'(CYC - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/psram_page_step.sv
module psram_page_step #(
  parameter int ADDR_W  = 22,
  parameter int PAGE_W  = 4,
  parameter int CE_W    = 10,
  parameter int APA_CYC = 2,
  parameter int CEM_CYC = 1000
) (
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [CE_W-1:0]   ce_cnt_i,
  input  logic              page_en_i,
  output logic [ADDR_W-1:0] next_addr_o,
  output logic              stay_o
);
  logic [CE_W:0] budget;
  assign budget      = {1'b0, ce_cnt_i} + (CE_W+1)'(APA_CYC);
  assign next_addr_o = cur_addr_i + ADDR_W'(1);
  // in-page step only if not at page end and chip-enable budget allows it
  assign stay_o = page_en_i
               && (cur_addr_i[PAGE_W-1:0] != {PAGE_W{1'b1}})
               && (budget <= (CE_W+1)'(CEM_CYC));
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int PAGE_W    = 4,
  parameter int CLK_PS    = 10000,
  parameter int T_AA_PS   = 70000,
  parameter int T_APA_PS  = 20000,
  parameter int T_WP_PS   = 46000,
  parameter int T_DW_PS   = 23000,
  parameter int T_CEM_PS  = 10000000,
  parameter int T_PU_PS   = 150000000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  page_en_i,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [DATA_W/8-1:0]   be_i,
  input  logic [PAGE_W-1:0]     len_i,
  output logic                  ready_o,
  output logic                  rvalid_o,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  mem_ce_no,
  output logic                  mem_oe_no,
  output logic                  mem_we_no,
  output logic [DATA_W/8-1:0]   mem_be_no,
  output logic [ADDR_W-1:0]     mem_addr_o,
  input  logic [DATA_W-1:0]     mem_dq_i,
  output logic [DATA_W-1:0]     mem_dq_o,
  output logic                  mem_dq_oe_o
);
  localparam int LANES   = DATA_W / 8;
  localparam int AA_CYC  = ps2cyc(T_AA_PS, CLK_PS);
  localparam int APA_CYC = ps2cyc(T_APA_PS, CLK_PS);
  localparam int WP_CYC  = ps2cyc(T_WP_PS, CLK_PS);
  localparam int DW_CYC  = ps2cyc(T_DW_PS, CLK_PS);
  localparam int WR_CYC  = (WP_CYC > DW_CYC) ? WP_CYC : DW_CYC;
  localparam int CEM_CYC = ps2cyc(T_CEM_PS, CLK_PS);
  localparam int PU_CYC  = ps2cyc(T_PU_PS, CLK_PS);
  localparam int CNT_W   = $clog2(AA_CYC + APA_CYC + WR_CYC + 1);
  localparam int CE_W    = $clog2(CEM_CYC + APA_CYC + AA_CYC + 1);

  psram_st_e            state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [CE_W-1:0]      ce_cnt_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    wdata_q;
  logic [LANES-1:0]     be_q;
  logic [PAGE_W-1:0]    left_q;
  logic                 rvalid_q;
  logic [DATA_W-1:0]    rdata_q;

  logic                 pu_done;
  logic                 rd_act, wr_act;
  logic [DATA_W-1:0]    masked;
  logic [ADDR_W-1:0]    next_addr;
  logic                 stay;

  psram_pwrup_wait #(.CYC(PU_CYC)) u_pwrup (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_o(pu_done)
  );

  psram_page_step #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CE_W(CE_W),
    .APA_CYC(APA_CYC), .CEM_CYC(CEM_CYC)
  ) u_step (
    .cur_addr_i (addr_q),
    .ce_cnt_i   (ce_cnt_q),
    .page_en_i  (page_en_i),
    .next_addr_o(next_addr),
    .stay_o     (stay)
  );

  psram_lanes #(.LANES(LANES)) u_lanes (
    .be_i    (be_q),
    .active_i(rd_act | wr_act),
    .dq_i    (mem_dq_i),
    .lane_n_o(mem_be_no),
    .masked_o(masked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_PWR;
      cnt_q    <= '0;
      ce_cnt_q <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      be_q     <= '0;
      left_q   <= '0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= 1'b0;
      unique case (state_q)
        ST_PWR: if (pu_done) state_q <= ST_IDLE;
        ST_IDLE: if (req_i) begin
          addr_q <= addr_i;
          be_q   <= be_i;
          if (we_i) begin
            wdata_q <= wdata_i;
            cnt_q   <= CNT_W'(WR_CYC - 1);
            state_q <= ST_WR;
          end else begin
            left_q   <= len_i;
            cnt_q    <= CNT_W'(AA_CYC - 1);
            ce_cnt_q <= CE_W'(1);
            state_q  <= ST_RD;
          end
        end
        ST_RD, ST_PG: begin
          if (cnt_q != '0) begin
            cnt_q    <= cnt_q - CNT_W'(1);
            ce_cnt_q <= ce_cnt_q + CE_W'(1);
          end else begin
            rvalid_q <= 1'b1;
            rdata_q  <= masked;
            if (left_q == '0) begin
              state_q <= ST_IDLE;
            end else begin
              left_q <= left_q - PAGE_W'(1);
              addr_q <= next_addr;
              if (stay) begin
                cnt_q    <= CNT_W'(APA_CYC - 1);
                ce_cnt_q <= ce_cnt_q + CE_W'(1);
                state_q  <= ST_PG;
              end else begin
                state_q  <= ST_GAP;
              end
            end
          end
        end
        ST_GAP: begin
          cnt_q    <= CNT_W'(AA_CYC - 1);
          ce_cnt_q <= CE_W'(1);
          state_q  <= ST_RD;
        end
        ST_WR: begin
          if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
          else             state_q <= ST_WEND;
        end
        ST_WEND: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_act      = (state_q == ST_RD) || (state_q == ST_PG);
  assign wr_act      = (state_q == ST_WR);
  assign mem_ce_no   = ~(rd_act | wr_act);
  assign mem_oe_no   = ~rd_act;
  assign mem_we_no   = ~wr_act;
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  // keep driving through the cycle in which write enable rises
  assign mem_dq_oe_o = wr_act | (state_q == ST_WEND);
  assign ready_o     = (state_q == ST_IDLE);
  assign rvalid_o    = rvalid_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
  parameter int ADDR_W  = 22,
  parameter int PAGE_W  = 4,
  parameter int PU_CYC  = 15000,
  parameter int CEM_CYC = 1000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic              mem_ce_no,
  input logic              mem_oe_no,
  input logic              mem_we_no,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_dq_oe_o
);
  localparam int UP_W = $clog2(PU_CYC + 1);
  localparam int RUN_W = $clog2(CEM_CYC + 2);

  logic [UP_W-1:0]  up_cnt;
  logic [RUN_W-1:0] ce_run;
  logic             started;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_cnt  <= '0;
      ce_run  <= '0;
      started <= 1'b0;
    end else begin
      started <= 1'b1;
      if (up_cnt != UP_W'(PU_CYC)) up_cnt <= up_cnt + UP_W'(1);
      if (mem_ce_no)                      ce_run <= '0;
      else if (ce_run != {RUN_W{1'b1}})   ce_run <= ce_run + RUN_W'(1);
    end
  end

  p_pwrup_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt < UP_W'(PU_CYC)) |-> (mem_ce_no && !ready_o));

  p_rvalid_after_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && rvalid_o) |-> $past(!mem_ce_no && !mem_oe_no));

  p_write_pins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_ce_no && mem_oe_no && mem_dq_oe_o));

  p_page_high_bits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && !mem_ce_no && $past(!mem_ce_no))
      |-> (mem_addr_o[ADDR_W-1:PAGE_W] == $past(mem_addr_o[ADDR_W-1:PAGE_W])));

  p_ce_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no |-> (ce_run < RUN_W'(CEM_CYC)));

  p_no_clash_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_dq_oe_o && !mem_oe_no));

  p_release_before_oe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && $fell(mem_oe_no)) |-> $past(!mem_dq_oe_o));
endmodule

bind psram_ctrl psram_ctrl_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PU_CYC(PU_CYC), .CEM_CYC(CEM_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ready_o    (ready_o),
  .rvalid_o   (rvalid_o),
  .mem_ce_no  (mem_ce_no),
  .mem_oe_no  (mem_oe_no),
  .mem_we_no  (mem_we_no),
  .mem_addr_o (mem_addr_o),
  .mem_dq_oe_o(mem_dq_oe_o)
);

// File: tb/tb_psram_ctrl.sv
`timescale 1ns/1ps
module tb_psram_ctrl;
  localparam int CLK_NS = 10;
  localparam int CLK_PS = CLK_NS * 1000;
  // bench-side cycle counts from the requirement formulas
  localparam int AA  = (70000 + CLK_PS - 1) / CLK_PS;
  localparam int APA = (20000 + CLK_PS - 1) / CLK_PS;
  localparam int WR  = 5;
  localparam int CEM = (120000 + CLK_PS - 1) / CLK_PS;
  localparam int PU  = (2000000 + CLK_PS - 1) / CLK_PS;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic page_en_i = 1'b0, req_i = 1'b0, we_i = 1'b0;
  logic [21:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [1:0]  be_i = 2'b11;
  logic [3:0]  len_i = '0;
  logic ready_o, rvalid_o;
  logic [15:0] rdata_o;
  logic mem_ce_no, mem_oe_no, mem_we_no;
  logic [1:0] mem_be_no;
  logic [21:0] mem_addr_o;
  logic [15:0] mem_dq_i, mem_dq_o;
  logic mem_dq_oe_o;

  always #(CLK_NS/2) clk = ~clk;

  psram_ctrl #(.CLK_PS(CLK_PS), .T_CEM_PS(120000), .T_PU_PS(2000000)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .page_en_i(page_en_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .be_i(be_i), .len_i(len_i),
    .ready_o(ready_o), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
    .mem_ce_no(mem_ce_no), .mem_oe_no(mem_oe_no), .mem_we_no(mem_we_no),
    .mem_be_no(mem_be_no), .mem_addr_o(mem_addr_o), .mem_dq_i(mem_dq_i),
    .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o)
  );

  // memory model and independent expected image
  logic [15:0] model_mem [0:255];
  logic [15:0] shadow    [0:255];
  initial for (int i = 0; i < 256; i++) begin
    model_mem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
    shadow[i]    = 16'(i * 16'h0101) ^ 16'h5A3C;
  end

  always_comb begin
    mem_dq_i[7:0]  = (!mem_ce_no && !mem_oe_no && !mem_be_no[0]) ? model_mem[mem_addr_o[7:0]][7:0]  : 8'hEE;
    mem_dq_i[15:8] = (!mem_ce_no && !mem_oe_no && !mem_be_no[1]) ? model_mem[mem_addr_o[7:0]][15:8] : 8'hEE;
  end

  always @(negedge clk) if (rst_ni && !mem_ce_no && !mem_we_no) begin
    if (!mem_be_no[0]) model_mem[mem_addr_o[7:0]][7:0]  = mem_dq_o[7:0];
    if (!mem_be_no[1]) model_mem[mem_addr_o[7:0]][15:8] = mem_dq_o[15:8];
  end

  int n_chk = 0, n_fail = 0;
  int cyc;
  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // scoreboard queues
  logic [15:0] exp_d[$];
  int          exp_c[$];
  string       exp_r[$];

  // monitor
  bit prev_ce = 1, prev_we = 1, prev_oe = 1, prev_dqoe = 0;
  int ce_run = 0, we_len = 0, we_pulses = 0;
  logic [17:0] hi_addr;
  bit hi_bad = 0, we_bad = 0;
  logic [15:0] we_data;

  always @(negedge clk) if (rst_ni) begin
    if (rvalid_o) begin
      if (exp_d.size() == 0) chk(0, "R2", "unexpected rvalid", 32'(rdata_o), 0);
      else begin
        logic [15:0] d; int c; string r;
        d = exp_d.pop_front(); c = exp_c.pop_front(); r = exp_r.pop_front();
        chk(rdata_o == d, r, "read data", 32'(rdata_o), 32'(d));
        chk(cyc == c, r, "read word cycle", 32'(cyc), 32'(c));
      end
    end
    if (!mem_ce_no) begin
      if (prev_ce) begin ce_run = 1; hi_addr = mem_addr_o[21:4]; end
      else begin
        ce_run++;
        if (mem_addr_o[21:4] != hi_addr) hi_bad = 1;
      end
    end else if (!prev_ce) begin
      chk(ce_run <= CEM, "R8", "chip enable low run", 32'(ce_run), 32'(CEM));
      chk(!hi_bad, "R5", "page address high bits stable", 32'(hi_bad), 0);
      hi_bad = 0;
    end
    if (mem_dq_oe_o && !mem_oe_no) chk(0, "R9", "bus driven with output enable low", 1, 0);
    if (!mem_oe_no && prev_oe) chk(!prev_dqoe, "R9", "drive released before output enable", 32'(prev_dqoe), 0);
    if (!mem_we_no) begin
      if (prev_we) begin we_len = 0; we_data = mem_dq_o; we_bad = 0; end
      we_len++;
      if (!mem_dq_oe_o || mem_dq_o != we_data || !mem_oe_no || mem_ce_no) we_bad = 1;
    end else if (!prev_we) begin
      we_pulses++;
      chk(we_len == WR, "R3", "write pulse width", 32'(we_len), 32'(WR));
      chk(!we_bad && mem_dq_oe_o && mem_dq_o == we_data, "R3", "write data held through pulse end",
          32'(mem_dq_o), 32'(we_data));
    end
    prev_ce = mem_ce_no; prev_we = mem_we_no; prev_oe = mem_oe_no; prev_dqoe = mem_dq_oe_o;
  end

  function automatic logic [15:0] expd(input logic [21:0] a, input logic [1:0] be);
    return {be[1] ? shadow[a[7:0]][15:8] : 8'h00, be[0] ? shadow[a[7:0]][7:0] : 8'h00};
  endfunction

  task automatic wait_idle();
    @(negedge clk);
    while (!(ready_o && exp_d.size() == 0)) @(negedge clk);
  endtask

  task automatic do_read(input logic [21:0] a, input int len, input logic [1:0] be,
                         input bit pg, input string rq);
    int t, cc; logic [21:0] aa;
    wait_idle();
    page_en_i = pg; addr_i = a; len_i = 4'(len); be_i = be; we_i = 1'b0; req_i = 1'b1;
    t = cyc + 1 + AA; cc = AA; aa = a;
    for (int k = 0; k <= len; k++) begin
      exp_d.push_back(expd(aa, be)); exp_c.push_back(t); exp_r.push_back(rq);
      if (k < len) begin
        if (pg && aa[3:0] != 4'hF && cc + APA <= CEM) begin t += APA; cc += APA; end
        else begin t += 1 + AA; cc = AA; end
        aa = aa + 22'd1;
      end
    end
    @(negedge clk) req_i = 1'b0;
    wait_idle();
  endtask

  task automatic do_write(input logic [21:0] a, input logic [15:0] d, input logic [1:0] be,
                          input int len, input string rq);
    int p0;
    wait_idle();
    addr_i = a; wdata_i = d; be_i = be; len_i = 4'(len); we_i = 1'b1; req_i = 1'b1;
    p0 = we_pulses;
    @(negedge clk) begin req_i = 1'b0; we_i = 1'b0; end
    if (be[0]) shadow[a[7:0]][7:0]  = d[7:0];
    if (be[1]) shadow[a[7:0]][15:8] = d[15:8];
    wait_idle();
    chk(we_pulses - p0 == 1, rq, "write pulses per request", 32'(we_pulses - p0), 1);
  endtask

  bit finished = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit ce_all_high;
    int rdy_cyc;
    repeat (3) @(negedge clk);
    chk(mem_ce_no == 1, "R1", "chip enable in reset", 32'(mem_ce_no), 1);
    chk(ready_o == 0, "R1", "ready in reset", 32'(ready_o), 0);
    chk(mem_dq_oe_o == 0 && rvalid_o == 0, "R1", "drive/rvalid in reset",
        32'({mem_dq_oe_o, rvalid_o}), 0);
    rst_ni = 1'b1;
    ce_all_high = 1; rdy_cyc = -1;
    while (rdy_cyc < 0) begin
      @(negedge clk);
      // R11: a write request raised during power-up must be dropped
      if (cyc == 20) begin addr_i = 22'h70; wdata_i = 16'h0BAD; be_i = 2'b11; we_i = 1'b1; req_i = 1'b1; end
      if (cyc == 30) begin req_i = 1'b0; we_i = 1'b0; end
      if (!mem_ce_no) ce_all_high = 0;
      if (ready_o) rdy_cyc = cyc;
    end
    chk(rdy_cyc == PU, "R1", "first ready edge", 32'(rdy_cyc), 32'(PU));
    chk(ce_all_high, "R1", "chip enable high during power-up", 0, 1);
    chk(we_pulses == 0, "R11", "write pulses during power-up", 32'(we_pulses), 0);

    do_write(22'h10, 16'h1234, 2'b11, 0, "R3");
    do_write(22'h11, 16'hABCD, 2'b01, 0, "R4");
    do_write(22'h12, 16'h9876, 2'b10, 0, "R4");
    do_read(22'h10, 0, 2'b11, 0, "R2");
    do_read(22'h11, 0, 2'b01, 0, "R4");
    do_read(22'h11, 0, 2'b11, 0, "R4");
    do_read(22'h12, 0, 2'b11, 1, "R4");
    do_read(22'h70, 0, 2'b11, 0, "R11");
    do_read(22'h20, 2, 2'b11, 1, "R5");
    do_read(22'h2E, 3, 2'b11, 1, "R6");
    do_read(22'h30, 2, 2'b10, 0, "R7");
    do_read(22'h40, 5, 2'b11, 1, "R8");
    do_write(22'h50, 16'hC0DE, 2'b11, 5, "R10");
    do_read(22'h50, 1, 2'b11, 1, "R10");

    // R11: request raised while a read is busy is dropped
    wait_idle();
    page_en_i = 0; addr_i = 22'h60; len_i = 0; be_i = 2'b11; we_i = 1'b0; req_i = 1'b1;
    exp_d.push_back(expd(22'h60, 2'b11)); exp_c.push_back(cyc + 1 + AA); exp_r.push_back("R11");
    @(negedge clk) req_i = 1'b0;
    @(negedge clk);
    chk(ready_o == 0, "R11", "ready while busy", 32'(ready_o), 0);
    addr_i = 22'h61; wdata_i = 16'hFFFF; we_i = 1'b1; req_i = 1'b1;
    @(negedge clk) begin req_i = 1'b0; we_i = 1'b0; end
    wait_idle();
    do_read(22'h61, 0, 2'b11, 0, "R11");

    chk(exp_d.size() == 0, "R2", "pending reads at end", 32'(exp_d.size()), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule